// File: doc/BRIEF.md
# Matrix Keypad Scan Controller

This block scans a key matrix of up to sixteen drive lines by eight sense lines. While it waits for a key, it drives every row that is not masked at once. The first column that reads high sets a keypress flag and starts a full scan. A full scan begins with a short lead-in. It then drives one row at a time for a fixed sixteen-cycle slot plus a programmable debounce stretch. A column is taken as pressed only if it reads high on each of the last debounce+1 cycles of its row's slot.

Pressed keys are gathered into a small buffer in scan order and published to the host as a whole at the end of each scan. Each entry is a byte that holds a valid flag, the row and the column. While any key is held, the matrix is scanned again after an idle gap that the host programs. After a scan that finds no key, the controller keeps polling with all rows driven for a programmable number of cycles, then drops back to the waiting state. The host sees a small register port with no read side effects. There are two interrupt sources: the keypress flag and an entry-count threshold.

Top module: `keypad_scan`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `rowDrive` is 0. While the enable bit is 0, `rowDrive` stays 0.
- R2: While enabled and waiting, `rowDrive` equals the inverse of the row mask. A high column starts a scan and sets status bit 0.
- R3: A scan started by a key seen at clock edge E publishes its result at edge E + 5 + ROWS*(16+debounce). During the scan `rowDrive` is one-hot, stepping from row 0 upward.
- R4: The debounce count (control bits [13:4], 10 bits, so at most 1023) lengthens every row slot by that many cycles.
- R5: Entry i is the byte {valid, row[3:0], col[2:0]}. It sits at bits [8*(i%4)+7 : 8*(i%4)] of word 5 for i<4, and of word 6 otherwise. Entries fill in scan order, row ascending then column ascending, and unused entries read 0.
- R6: Status bits [7:4] hold the entry count of the last scan. At most 8 keys are kept, the first 8 in scan order.
- R7: Writing 1 to status bit 0 or bit 2 clears that bit. The count field is unaffected by writes.
- R8: At the end of a scan, status bit 2 is set when the threshold (control bits [17:14]) is nonzero and the count is at or above it.
- R9: `irq` is (status bit 0 AND control bit 1) OR (status bit 2 AND control bit 3).
- R10: A row whose mask bit (word 4) is 1 is not driven while waiting. A key in that row alone neither sets status bit 0 nor starts a scan.
- R11: While keys are held, the matrix is rescanned after the idle gap (word 2) and changes in the held set are published. After a release, the next scan publishes a count of 0.
- R12: After an empty scan, all rows are driven for the number of cycles held in word 3, then waiting resumes. A key during that window rescans without setting status bit 0. A value of 0 resumes waiting at once.
- R13: Word addresses are 0 control, 1 status, 2 idle gap, 3 polling window, 4 row mask, 5 and 6 entries. Control bit 0 is enable, bit 1 is keypress interrupt enable and bit 3 is threshold interrupt enable. The control word reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| rowDrive | output | ROWS | Active-high row drive |
| colSense | input | COLS | Active-high column sense |
| irq | output | 1 | Interrupt request |

## Verification
A scan that starts from the waiting state, or from the polling window, publishes its result exactly 1 + 5 + ROWS*(16+debounce) falling edges after the key appears on the falling edge before the detecting clock. The bench compares that count exactly for the 16-cycle and 20-cycle row slots. Results that follow a change in the held keys arrive after an idle gap plus a scan of unknown phase, so for those the bench only waits for the next change in published state. Key changes are made within the idle gap right after a publication, so no scan sees a half-changed matrix. The polling window is probed two cycles before and at its programmed end.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;
  localparam int ROW_IDX_W       = 4;
  localparam int COL_IDX_W       = 3;
  localparam int ENT_BYTE_W      = 8;
  localparam int LEAD_CYCLES     = 5;
  localparam int ROW_BASE_CYCLES = 16;
  localparam int DEB_W           = 10;
  localparam int THR_W           = 4;
  localparam int DEB_LSB         = 4;
  localparam int THR_LSB         = 14;
  localparam int CTRL_W          = THR_LSB + THR_W;
  localparam int EN_BIT          = 0;
  localparam int KPIE_BIT        = 1;
  localparam int FIFOIE_BIT      = 3;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_GAP    = 3'd2;
  localparam logic [2:0] A_HOLD   = 3'd3;
  localparam logic [2:0] A_MASK   = 3'd4;
  localparam logic [2:0] A_ENT_LO = 3'd5;
  localparam logic [2:0] A_ENT_HI = 3'd6;

  typedef struct packed {
    logic                 kpSet;
    logic                 accLoad;
    logic                 accAnd;
    logic                 rowEnd;
    logic                 lastRow;
    logic [ROW_IDX_W-1:0] rowIdx;
  } scanStrobe_t;
endpackage

// File: rtl/keypad_scan_regs.sv
module keypad_scan_regs
  import keypad_scan_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int COLS    = 8,
  parameter int ENTRIES = 8,
  parameter int TMR_W   = 16,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [COLS-1:0]   colSense,
  input  scanStrobe_t       strobe,
  output logic              en,
  output logic              kpIe,
  output logic              fifoIe,
  output logic [DEB_W-1:0]  deb,
  output logic [TMR_W-1:0]  gapCnt,
  output logic [TMR_W-1:0]  holdCnt,
  output logic [ROWS-1:0]   rowMask,
  output logic              commitHasKeys,
  output logic              irq,
  output logic [CNT_W-1:0]  entCount,
  output logic [ENTRIES-1:0] entValid
);
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int WIDE_W = 64;

  logic [CTRL_W-1:0]     ctrlReg;
  logic [TMR_W-1:0]      gapReg, holdReg;
  logic [ROWS-1:0]       maskReg;
  logic                  stKp, stFifo;
  logic [ENT_BYTE_W-1:0] entries [ENTRIES];
  logic [ENT_BYTE_W-1:0] pend    [ENTRIES];
  logic [ENT_BYTE_W-1:0] newPend [ENTRIES];
  logic [CNT_W-1:0]      entCnt, pendCnt, newCnt;
  logic [COLS-1:0]       acc, rowRes;
  logic [THR_W-1:0]      thr;
  logic                  commit, wrStat, fifoHit;
  logic [WIDE_W-1:0]     entWide;
  logic                  unusedWdata;

  assign unusedWdata = ^regWdata[31:CTRL_W];

  assign en      = ctrlReg[EN_BIT];
  assign kpIe    = ctrlReg[KPIE_BIT];
  assign fifoIe  = ctrlReg[FIFOIE_BIT];
  assign deb     = ctrlReg[DEB_LSB +: DEB_W];
  assign thr     = ctrlReg[THR_LSB +: THR_W];
  assign gapCnt  = gapReg;
  assign holdCnt = holdReg;
  assign rowMask = maskReg;

  // Debounced row sample and append of this row's keys to the pending list
  always_comb begin
    rowRes  = strobe.accLoad ? colSense : (acc & colSense);
    newPend = pend;
    newCnt  = pendCnt;
    for (int c = 0; c < COLS; c++) begin
      if (rowRes[c] && (newCnt < CNT_W'(ENTRIES))) begin
        newPend[newCnt[IDX_W-1:0]] = {1'b1, strobe.rowIdx, COL_IDX_W'(c)};
        newCnt = newCnt + 1'b1;
      end
    end
  end

  assign commit        = strobe.rowEnd & strobe.lastRow;
  assign commitHasKeys = (newCnt != '0);
  assign wrStat        = regWe && (regAddr == A_STAT);
  assign fifoHit       = commit && (thr != '0) && (32'(newCnt) >= 32'(thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
      gapReg  <= '0;
      holdReg <= '0;
      maskReg <= '0;
      stKp    <= 1'b0;
      stFifo  <= 1'b0;
      acc     <= '0;
      pendCnt <= '0;
      entCnt  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pend[i]    <= '0;
        entries[i] <= '0;
      end
    end else begin
      if (regWe) begin
        case (regAddr)
          A_CTRL:  ctrlReg <= regWdata[CTRL_W-1:0];
          A_GAP:   gapReg  <= regWdata[TMR_W-1:0];
          A_HOLD:  holdReg <= regWdata[TMR_W-1:0];
          A_MASK:  maskReg <= regWdata[ROWS-1:0];
          default: ;
        endcase
      end
      stKp   <= strobe.kpSet | (stKp & ~(wrStat & regWdata[0]));
      stFifo <= fifoHit | (stFifo & ~(wrStat & regWdata[2]));

      if (strobe.accLoad)     acc <= colSense;
      else if (strobe.accAnd) acc <= acc & colSense;

      if (!en || commit) begin
        pendCnt <= '0;
        for (int i = 0; i < ENTRIES; i++) pend[i] <= '0;
      end else if (strobe.rowEnd) begin
        pendCnt <= newCnt;
        pend    <= newPend;
      end

      if (commit) begin
        entCnt  <= newCnt;
        entries <= newPend;
      end
    end
  end

  always_comb begin
    entWide = '0;
    for (int i = 0; i < ENTRIES; i++) entWide[i*ENT_BYTE_W +: ENT_BYTE_W] = entries[i];
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
    assign entValid[g] = entries[g][ENT_BYTE_W-1];
  end

  assign entCount = entCnt;
  assign irq      = (stKp & kpIe) | (stFifo & fifoIe);

  always_comb begin
    case (regAddr)
      A_CTRL:   regRdata = 32'(ctrlReg);
      A_STAT:   regRdata = 32'({entCnt, 1'b0, stFifo, 1'b0, stKp});
      A_GAP:    regRdata = 32'(gapReg);
      A_HOLD:   regRdata = 32'(holdReg);
      A_MASK:   regRdata = 32'(maskReg);
      A_ENT_LO: regRdata = entWide[31:0];
      A_ENT_HI: regRdata = entWide[63:32];
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/keypad_scan_ctrl.sv
module keypad_scan_ctrl
  import keypad_scan_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DEB_W-1:0] deb,
  input  logic [TMR_W-1:0] gapCnt,
  input  logic [TMR_W-1:0] holdCnt,
  input  logic [ROWS-1:0]  rowMask,
  input  logic [COLS-1:0]  colSense,
  input  logic             commitHasKeys,
  output logic [ROWS-1:0]  rowDrive,
  output scanStrobe_t      strobe
);
  localparam int CNT_W = (TMR_W > DEB_W + 1) ? TMR_W : DEB_W + 1;

  typedef enum logic [2:0] {ST_WAIT, ST_LEAD, ST_ROW, ST_GAP, ST_POLL} scanState_e;

  scanState_e           state;
  logic [CNT_W-1:0]     cnt;
  logic [ROW_IDX_W-1:0] rowIdx;
  logic [CNT_W-1:0]     rowLast;
  logic                 anyCol, lastRow, rowEnd;

  assign anyCol  = |colSense;
  assign rowLast = CNT_W'(ROW_BASE_CYCLES - 1) + CNT_W'(deb);
  assign lastRow = (rowIdx == ROW_IDX_W'(ROWS - 1));
  assign rowEnd  = (state == ST_ROW) && (cnt == rowLast);

  always_comb begin
    rowDrive = '0;
    if (en) begin
      case (state)
        ST_WAIT: rowDrive = ~rowMask;
        ST_ROW:  rowDrive = {{(ROWS-1){1'b0}}, 1'b1} << rowIdx;
        ST_POLL: rowDrive = '1;
        default: rowDrive = '0;
      endcase
    end
  end

  always_comb begin
    strobe.kpSet   = en && (state == ST_WAIT) && anyCol;
    strobe.accLoad = (state == ST_ROW) && (cnt == CNT_W'(ROW_BASE_CYCLES - 1));
    strobe.accAnd  = (state == ST_ROW) && (cnt > CNT_W'(ROW_BASE_CYCLES - 1));
    strobe.rowEnd  = rowEnd;
    strobe.lastRow = lastRow;
    strobe.rowIdx  = rowIdx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_WAIT;
      cnt    <= '0;
      rowIdx <= '0;
    end else if (!en) begin
      state  <= ST_WAIT;
      cnt    <= '0;
      rowIdx <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          cnt <= '0;
          if (anyCol) state <= ST_LEAD;
        end
        ST_LEAD: begin
          if (cnt == CNT_W'(LEAD_CYCLES - 1)) begin
            state  <= ST_ROW;
            cnt    <= '0;
            rowIdx <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_ROW: begin
          if (rowEnd) begin
            cnt <= '0;
            if (!lastRow) rowIdx <= rowIdx + 1'b1;
            else if (commitHasKeys) state <= (gapCnt == '0) ? ST_LEAD : ST_GAP;
            else state <= (holdCnt == '0) ? ST_WAIT : ST_POLL;
          end else cnt <= cnt + 1'b1;
        end
        ST_GAP: begin
          if (CNT_W'(cnt + 1'b1) == CNT_W'(gapCnt)) begin
            state <= ST_LEAD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_POLL: begin
          if (anyCol) begin
            state <= ST_LEAD;
            cnt   <= '0;
          end else if (CNT_W'(cnt + 1'b1) == CNT_W'(holdCnt)) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/keypad_scan.sv
module keypad_scan
  import keypad_scan_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int COLS    = 8,
  parameter int ENTRIES = 8,
  parameter int TMR_W   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            regWe,
  input  logic [2:0]      regAddr,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  output logic [ROWS-1:0] rowDrive,
  input  logic [COLS-1:0] colSense,
  output logic            irq
);
  localparam int ENT_CNT_W = $clog2(ENTRIES + 1);

  scanStrobe_t            strobe;
  logic                   en, kpIe, fifoIe, commitHasKeys;
  logic [DEB_W-1:0]       deb;
  logic [TMR_W-1:0]       gapCnt, holdCnt;
  logic [ROWS-1:0]        rowMask;
  logic [ENT_CNT_W-1:0]   entCount;
  logic [ENTRIES-1:0]     entValid;

  keypad_scan_regs #(.ROWS(ROWS), .COLS(COLS), .ENTRIES(ENTRIES), .TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .colSense(colSense), .strobe(strobe), .en(en), .kpIe(kpIe),
    .fifoIe(fifoIe), .deb(deb), .gapCnt(gapCnt), .holdCnt(holdCnt), .rowMask(rowMask),
    .commitHasKeys(commitHasKeys), .irq(irq), .entCount(entCount), .entValid(entValid)
  );

  keypad_scan_ctrl #(.ROWS(ROWS), .COLS(COLS), .TMR_W(TMR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .deb(deb), .gapCnt(gapCnt), .holdCnt(holdCnt),
    .rowMask(rowMask), .colSense(colSense), .commitHasKeys(commitHasKeys),
    .rowDrive(rowDrive), .strobe(strobe)
  );
endmodule

// File: rtl/keypad_scan_chk.sv
module keypad_scan_chk #(
  parameter int ROWS    = 16,
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               kpIe,
  input logic               fifoIe,
  input logic               irq,
  input logic [ROWS-1:0]    rowDrive,
  input logic [ROWS-1:0]    rowMask,
  input logic [CNT_W-1:0]   entCount,
  input logic [ENTRIES-1:0] entValid
);
  // R1: disabled controller drives no row
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (rowDrive == '0));

  // R6: published count never exceeds the buffer
  a_r6_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(entCount) <= ENTRIES);

  // R5: valid flags are a packed prefix whose length is the count
  a_r5_valid_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    32'(entValid) == ((32'd1 << entCount) - 32'd1));

  // R9: an interrupt needs at least one enabled source
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (kpIe || fifoIe));

  // R3, R10, R12: several rows at once only while waiting or polling
  a_r3_drive_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ($countones(rowDrive) > 1)) |-> ((rowDrive == '1) || (rowDrive == ~rowMask)));
endmodule

bind keypad_scan keypad_scan_chk #(.ROWS(ROWS), .ENTRIES(ENTRIES), .CNT_W(ENT_CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .kpIe(kpIe), .fifoIe(fifoIe), .irq(irq),
  .rowDrive(rowDrive), .rowMask(rowMask), .entCount(entCount), .entValid(entValid)
);

// File: tb/keypad_scan_tb.sv
`timescale 1ns/1ps
module keypad_scan_tb;
  localparam int ROWS = 16;
  localparam int COLS = 8;
  localparam int DUE0 = 1 + 5 + ROWS * 16;
  localparam int DUE4 = 1 + 5 + ROWS * 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            regWe = 1'b0;
  logic [2:0]      regAddr = 3'd0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [ROWS-1:0] rowDrive;
  logic [COLS-1:0] colSense;
  logic            irq;
  logic [COLS-1:0] keyMat [ROWS];

  int nChecks = 0;
  int nFail   = 0;

  typedef struct {
    int          due;
    logic [3:0]  cnt;
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } scanExp_t;
  scanExp_t expQ[$];
  logic [3:0]  lastCnt = '0;
  logic [31:0] lastLo  = '0;
  logic [31:0] lastHi  = '0;

  keypad_scan u_dut (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rowDrive(rowDrive), .colSense(colSense), .irq(irq)
  );

  always #2 clk = ~clk;

  always_comb begin
    colSense = '0;
    for (int r = 0; r < ROWS; r++) if (rowDrive[r]) colSense = colSense | keyMat[r];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readNow(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #0.1;
    d = regRdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    readNow(a, d);
  endtask

  task automatic clearKeys();
    for (int r = 0; r < ROWS; r++) keyMat[r] = '0;
  endtask

  task automatic expectScan(input int due, input logic [3:0] cnt, input logic [31:0] lo,
                            input logic [31:0] hi, input string tag);
    scanExp_t e;
    e.due = due; e.cnt = cnt; e.lo = lo; e.hi = hi; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: waits for the next change of published scan state and scores it
  task automatic monitorNext();
    scanExp_t    e;
    logic [31:0] st, lo, hi;
    int          k;
    e = expQ.pop_front();
    k = 0;
    for (int n = 1; n <= 3000; n++) begin
      @(negedge clk);
      readNow(3'd1, st);
      readNow(3'd5, lo);
      readNow(3'd6, hi);
      if ((st[7:4] != lastCnt) || (lo != lastLo) || (hi != lastHi)) begin
        k = n;
        break;
      end
    end
    check(st[7:4] == e.cnt, {e.tag, " count"}, 32'(st[7:4]), 32'(e.cnt));
    check(lo == e.lo, {e.tag, " entries lo"}, lo, e.lo);
    check(hi == e.hi, {e.tag, " entries hi"}, hi, e.hi);
    if (e.due > 0) check(k == e.due, {e.tag, " publish cycle"}, 32'(k), 32'(e.due));
    lastCnt = st[7:4]; lastLo = lo; lastHi = hi;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    clearKeys();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(3'd0, d); check(d == 0, "R1 ctrl after reset", d, 0);
    rd(3'd1, d); check(d == 0, "R1 status after reset", d, 0);
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    check(rowDrive == '0, "R1 rowDrive after reset", 32'(rowDrive), 0);

    // R2, R13: enable with keypress interrupt
    wr(3'd2, 32'd20);
    wr(3'd3, 32'd40);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h3);
    @(negedge clk);
    check(rowDrive == 16'hFFFF, "R2 waiting drives all unmasked rows", 32'(rowDrive), 32'hFFFF);

    // R3, R5: single key row 2 col 5
    @(negedge clk);
    keyMat[2][5] = 1'b1;
    expectScan(DUE0, 4'd1, 32'h00000095, 32'h0, "R3 R5 single key");
    monitorNext();

    // R2, R9, R7: keypress flag, irq, write-1-to-clear
    readNow(3'd1, d); check(d == 32'h11, "R2 keypress flag set", d, 32'h11);
    check(irq == 1'b1, "R9 irq from keypress", 32'(irq), 1);
    wr(3'd1, 32'h1);
    readNow(3'd1, d); check(d == 32'h10, "R7 clear keeps count", d, 32'h10);
    check(irq == 1'b0, "R9 irq drops after clear", 32'(irq), 0);

    // R11, R5: held set changes to three keys
    clearKeys();
    keyMat[1][0] = 1'b1; keyMat[1][7] = 1'b1; keyMat[9][3] = 1'b1;
    expectScan(0, 4'd3, 32'h00CB8F88, 32'h0, "R11 R5 three keys scan order");
    monitorNext();

    // R6: nine keys, first eight kept
    clearKeys();
    keyMat[0] = 8'hFF; keyMat[3][1] = 1'b1;
    expectScan(0, 4'd8, 32'h83828180, 32'h87868584, "R6 overflow keeps first eight");
    monitorNext();
    readNow(3'd1, d); check(d[2] == 1'b0, "R8 no threshold flag when threshold 0", d, 32'h80);

    // R8, R9, R13: threshold 3 with its interrupt enabled
    wr(3'd0, 32'h0000C00B);
    clearKeys();
    keyMat[5][0] = 1'b1; keyMat[5][1] = 1'b1; keyMat[6][2] = 1'b1;
    expectScan(0, 4'd3, 32'h00B2A9A8, 32'h0, "R8 three keys at threshold");
    monitorNext();
    readNow(3'd1, d); check(d == 32'h34, "R8 threshold flag set", d, 32'h34);
    check(irq == 1'b1, "R9 irq from threshold", 32'(irq), 1);
    keyMat[5][1] = 1'b0;
    wr(3'd1, 32'h4);
    expectScan(0, 4'd2, 32'h0000B2A8, 32'h0, "R8 two keys below threshold");
    monitorNext();
    readNow(3'd1, d); check(d == 32'h20, "R8 no flag below threshold", d, 32'h20);
    rd(3'd0, d); check(d == 32'h0000C00B, "R13 control read back", d, 32'h0000C00B);

    // R11, R12: release, empty scan, polling window of 40 cycles
    wr(3'd0, 32'h3);
    wr(3'd4, 32'h1);
    clearKeys();
    expectScan(0, 4'd0, 32'h0, 32'h0, "R11 release publishes zero");
    monitorNext();
    check(rowDrive == 16'hFFFF, "R12 polling drives all rows", 32'(rowDrive), 32'hFFFF);
    repeat (38) @(negedge clk);
    check(rowDrive == 16'hFFFF, "R12 still polling before window end", 32'(rowDrive), 32'hFFFF);
    repeat (2) @(negedge clk);
    check(rowDrive == 16'hFFFE, "R12 back to waiting after window", 32'(rowDrive), 32'hFFFE);

    // R10: masked row key ignored while waiting
    keyMat[0][4] = 1'b1;
    repeat (300) @(negedge clk);
    readNow(3'd1, d); check(d == 32'h0, "R10 masked key no flag no scan", d, 32'h0);
    check(rowDrive == 16'hFFFE, "R10 masked row undriven", 32'(rowDrive), 32'hFFFE);

    // R3, R12: key during polling rescans without the keypress flag
    clearKeys();
    @(negedge clk);
    keyMat[3][3] = 1'b1;
    expectScan(DUE0, 4'd1, 32'h0000009B, 32'h0, "R3 key row 3 col 3");
    monitorNext();
    wr(3'd1, 32'h1);
    clearKeys();
    expectScan(0, 4'd0, 32'h0, 32'h0, "R11 second release");
    monitorNext();
    keyMat[4][4] = 1'b1;
    expectScan(DUE0, 4'd1, 32'h000000A4, 32'h0, "R12 rescan from polling");
    monitorNext();
    readNow(3'd1, d); check(d == 32'h10, "R12 no keypress flag from polling", d, 32'h10);

    // R12: zero window returns to waiting at once; R4: debounce 4
    wr(3'd3, 32'd0);
    clearKeys();
    expectScan(0, 4'd0, 32'h0, 32'h0, "R12 release with zero window");
    monitorNext();
    check(rowDrive == 16'hFFFE, "R12 zero window waits at once", 32'(rowDrive), 32'hFFFE);
    wr(3'd0, 32'h43);
    @(negedge clk);
    keyMat[7][1] = 1'b1;
    expectScan(DUE4, 4'd1, 32'h000000B9, 32'h0, "R4 debounce lengthens rows");
    monitorNext();

    // R1: disable
    wr(3'd0, 32'h0);
    @(negedge clk);
    check(rowDrive == '0, "R1 disabled rows idle", 32'(rowDrive), 0);
    check(irq == 1'b0, "R9 irq off when enables clear", 32'(irq), 0);
    check(expQ.size() == 0, "scoreboard drained", 32'(expQ.size()), 0);

    summary();
    $finish;
  end
endmodule